// File: doc/BRIEF.md
# Ten-Bit Serializer with Loopback Wrap

This block is the transmit half of a 10-bit serial link. A byte-rate reference strobe, sampled in the bit-clock domain, marks when a new pre-encoded 10-bit word is ready. On each low-to-high transition of that strobe the word is latched into a holding register. At the next word boundary it moves into a shift register and leaves one bit per bit clock, bit 0 first. The bit clock is the system clock, which runs at ten times the byte rate, so one word leaves per reference period. The block does no line coding: the words arrive already encoded.

A loopback control chooses where the serial stream goes. With loopback off, the external serial output carries the stream and the internal wrap output rests at 1. With loopback on, the external output is parked at a constant 1 and the stream appears only on the wrap output, which a receiver can take for tests that leave out the medium. When no word is pending, the stream idles at logic 1.

Top module: `ser10_wrap_tx`

## Requirements
- R1: While reset is asserted, and after it is released until the first word is loaded, both `ser_o` and `wrap_o` read 1.
- R2: A word is captured only on a clock edge at which `byte_ref_i` reads 1 and read 0 at the previous edge. Holding `byte_ref_i` high captures exactly one word.
- R3: The bits of a word leave least significant first: bit i is on the stream i bit clocks after bit 0.
- R4: When the shifter is idle, or the reference period is exactly 10 clocks, bit 0 of a captured word is on the stream one clock edge after the capture edge.
- R5: With a reference period of exactly 10 clocks, consecutive words leave back to back with no idle bit between them.
- R6: A capture that occurs while a word is shifting does not change any bit of that word.
- R7: When a word has finished and no captured word is waiting, the stream returns to 1.
- R8: With `loop_en_i` low, `ser_o` carries the stream and `wrap_o` reads 1.
- R9: With `loop_en_i` high, `ser_o` reads a constant 1 and `wrap_o` carries the stream.
- R10: If a second word is captured before the held word has moved into the shifter, the newer word replaces it and the older one is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, ten times the byte rate |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_ref_i | input | 1 | Byte-rate reference; its rising transition captures a word |
| tx_word_i | input | WORD_W (10) | Pre-encoded parallel word, bit 0 sent first |
| loop_en_i | input | 1 | 1 routes the stream to `wrap_o` and parks `ser_o` at 1 |
| ser_o | output | 1 | External serial output |
| wrap_o | output | 1 | Internal loopback serial output |

## Verification
The case hardest to reach from the ports is a held word being replaced before it drains. That needs two reference rises within the ten clocks of a word that is still shifting. It cannot happen at the nominal rate. The bench therefore runs directed pulse trains with short gaps over a word in flight, and random phases in which the reference period is drawn shorter than ten clocks. Every output bit is compared against a bench model built from the requirements. Loopback is toggled in the middle of words so that both outputs are checked while the stream is live.

// File: rtl/ser10_pkg.sv
package ser10_pkg;
    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_mode_e;
endpackage

// File: rtl/ser_ref_edge.sv
module ser_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    typedef struct packed {
        logic ref_seen;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ref_seen = ref_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = ref_i & ~st_q.ref_seen;

    // R2: a rise can never be reported on two consecutive edges
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ser_word_hold.sv
module ser_word_hold #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              take_i,
    output logic [WORD_W-1:0] held_o,
    output logic              full_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              full;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.word = word_i;
            st_d.full = 1'b1;
        end else if (take_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.word;
    assign full_o = st_q.full;

    // R2 / R10: a rise always leaves the newest word held
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (full_o && held_o == $past(word_i)));

    // R6: without a rise the held word is left alone
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> $stable(held_o));
endmodule

// File: rtl/ser_bit_shift.sv
module ser_bit_shift
    import ser10_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] held_i,
    input  logic              full_i,
    output logic              take_o,
    output logic              stream_o
);
    localparam int                CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        sh_mode_e          mode;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   boundary;

    always_comb begin
        st_d     = st_q;
        boundary = (st_q.mode == SH_IDLE) || (st_q.cnt == LAST);
        take_o   = boundary && full_i;
        if (take_o) begin
            st_d.sh   = held_i;
            st_d.cnt  = '0;
            st_d.mode = SH_RUN;
        end else if (st_q.mode == SH_RUN) begin
            if (st_q.cnt == LAST) begin
                st_d.mode = SH_IDLE;
            end else begin
                st_d.sh  = {1'b1, st_q.sh[WORD_W-1:1]};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.cnt  <= '0;
            st_q.mode <= SH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign stream_o = (st_q.mode == SH_RUN) ? st_q.sh[0] : 1'b1;

    // R4: the edge after a load presents bit 0 of the held word
    assert_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (stream_o == $past(held_i[0])));

    // R3: inside a word the next bit is the one above the current one
    assert_lsb_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SH_RUN && st_q.cnt != LAST) |=> (stream_o == $past(st_q.sh[1])));

    // R5: the bit counter stays inside one word
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/ser_wrap_sel.sv
module ser_wrap_sel (
    input  logic loop_i,
    input  logic stream_i,
    output logic ext_o,
    output logic wrap_o
);
    always_comb begin
        ext_o  = loop_i ? 1'b1 : stream_i;
        wrap_o = loop_i ? stream_i : 1'b1;
    end

    // R8 / R9: at least one of the two outputs always rests at 1
    always_comb begin
        assert_one_parked_R9: assert (ext_o || wrap_o);
    end
endmodule

// File: rtl/ser10_wrap_tx.sv
module ser10_wrap_tx #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_ref_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              loop_en_i,
    output logic              ser_o,
    output logic              wrap_o
);
    logic              rise;
    logic              take;
    logic              full;
    logic              stream;
    logic [WORD_W-1:0] held;

    ser_ref_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (byte_ref_i),
        .rise_o (rise)
    );

    ser_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .word_i (tx_word_i),
        .take_i (take),
        .held_o (held),
        .full_o (full)
    );

    ser_bit_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .held_i   (held),
        .full_i   (full),
        .take_o   (take),
        .stream_o (stream)
    );

    ser_wrap_sel u_sel (
        .loop_i   (loop_en_i),
        .stream_i (stream),
        .ext_o    (ser_o),
        .wrap_o   (wrap_o)
    );

    // R7: with nothing held and nothing loaded the stream goes idle
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !full && !$past(take) && $past(rst_n) && $past(take, 2) == 1'b0
         && $past(take, 3) == 1'b0 && $past(take, 4) == 1'b0 && $past(take, 5) == 1'b0
         && $past(take, 6) == 1'b0 && $past(take, 7) == 1'b0 && $past(take, 8) == 1'b0
         && $past(take, 9) == 1'b0 && $past(take, 10) == 1'b0 && $past(rst_n, 10))
        |=> (stream == 1'b1));
endmodule

// File: tb/test_ser10_wrap_tx.sv
module test_ser10_wrap_tx;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         byte_ref;
    logic [W-1:0] tx_word;
    logic         loop_en;
    logic         ser_o;
    logic         wrap_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model state
    logic [W-1:0] m_hold, m_sh;
    logic         m_full, m_act, m_refq;
    int           m_cnt;

    always #2.5 clk = ~clk;

    ser10_wrap_tx #(.WORD_W(W)) i_ser10_wrap_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_ref_i (byte_ref),
        .tx_word_i  (tx_word),
        .loop_en_i  (loop_en),
        .ser_o      (ser_o),
        .wrap_o     (wrap_o)
    );

    function automatic logic exp_stream();
        return m_act ? m_sh[0] : 1'b1;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hold = '0; m_sh = '1; m_full = 1'b0; m_act = 1'b0; m_refq = 1'b0; m_cnt = 0;
    endtask

    // advance the model by one edge using the values present before the edge
    task automatic model_step(input logic r, input logic [W-1:0] d);
        logic rise, bnd, ld;
        rise = r && !m_refq;
        bnd  = !m_act || (m_cnt == W - 1);
        ld   = bnd && m_full;
        if (ld) begin
            m_sh = m_hold; m_cnt = 0; m_act = 1'b1;
        end else if (m_act) begin
            if (m_cnt == W - 1) m_act = 1'b0;
            else begin m_sh = {1'b1, m_sh[W-1:1]}; m_cnt++; end
        end
        if (rise) begin m_hold = d; m_full = 1'b1; end
        else if (ld) m_full = 1'b0;
        m_refq = r;
    endtask

    task automatic tick(input logic r, input logic lp, input logic [W-1:0] d, input string req);
        @(negedge clk);
        byte_ref = r; loop_en = lp; tx_word = d;
        @(posedge clk);
        model_step(r, d);
        #1;
        chk(req, "ser_o",  ser_o,  lp ? 1'b1 : exp_stream());
        chk(req, "wrap_o", wrap_o, lp ? exp_stream() : 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; byte_ref = 1'b0; loop_en = 1'b0; tx_word = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "ser_o in reset",  ser_o,  1'b1);
        chk("R1", "wrap_o in reset", wrap_o, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] wa;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; byte_ref = 1'b0; loop_en = 1'b0; tx_word = '0;
        model_reset();
        do_reset();

        // R1: idle after reset release
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, W'($urandom), "R1");

        // R4 / R3: directed latency and bit order, independent of the model
        wa = 10'b1100101001;
        tick(1'b1, 1'b0, wa, "R2");
        for (int j = 0; j < W; j++) begin
            tick(1'b0, 1'b0, W'($urandom), "R3");
            chk("R4", "bit position", ser_o, wa[j]);
        end
        tick(1'b0, 1'b0, '0, "R7");
        chk("R7", "idle after word", ser_o, 1'b1);

        // R2: reference held high captures once only
        tick(1'b1, 1'b0, 10'h2AA, "R2");
        for (int i = 0; i < 25; i++) tick(1'b1, 1'b0, W'($urandom), "R2");
        chk("R2", "idle under held ref", ser_o, 1'b1);
        tick(1'b0, 1'b0, '0, "R2");

        // R5 / R9: nominal rate back to back, loopback on
        for (int k = 0; k < 6; k++)
            for (int p = 0; p < W; p++)
                tick(p < 5, 1'b1, W'($urandom), "R9");
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, '0, "R7");

        // R6 / R10: captures while a word shifts, second replaces first
        tick(1'b1, 1'b0, 10'h3C5, "R6");
        tick(1'b0, 1'b0, '0, "R6");
        tick(1'b0, 1'b0, '0, "R6");
        tick(1'b1, 1'b0, 10'h0F0, "R6");
        tick(1'b0, 1'b0, '0, "R10");
        tick(1'b0, 1'b0, '0, "R10");
        tick(1'b1, 1'b0, 10'h155, "R10");
        for (int i = 0; i < 25; i++) tick(1'b0, 1'b0, W'($urandom), "R10");

        // random phases: period and loopback drawn per word
        for (int k = 0; k < 300; k++) begin
            int per;
            logic lp;
            per = ($urandom % 4 == 0) ? 3 + int'($urandom % 12) : W;
            lp  = 1'($urandom);
            for (int p = 0; p < per; p++)
                tick(p < per / 2, (p == per / 3) ? ~lp : lp, W'($urandom), lp ? "R9" : "R8");
            if (k == 150) begin
                do_reset();
                tick(1'b0, 1'b0, '0, "R1");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule